// File: doc/BRIEF.md
# Multi-Lane DLL Bring-Up Sequencer

This block brings the delay-locked loops of a memory PHY out of reset in a fixed, timed order. There is one command-lane DLL and up to four byte-lane DLLs. A single pulse on `start` captures a 32-bit packed phase word and a bus-width select. The block then runs two passes. In the first pass it steps the command-lane DLL alone. In the second pass it steps every active byte-lane DLL together.

Each pass has three steps. The first step loads the phase and holds the DLL disabled and in reset. The second step releases both the disable and the reset controls. The third step raises the active-low reset release so the DLL runs. After each step the block waits a fixed time, which it converts to clock cycles from a clock-frequency parameter. A single-cycle `done` pulse marks the end of the final wait. Byte lanes that the bus width leaves unused keep whatever phase and control values they already held.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset every DLL disable output is 1, every nreset output is 0, all phase outputs are 0 and `done` is 0.
- R2: The command-lane phase output takes phase-word bits [21:16] when that lane's load step is applied. Word bits [31:22] have no effect.
- R3: Byte lane k (bit k of `dll_dis`/`dll_nrst`, k = 1..4) takes phase-word bits [4(k-1)+3 : 4(k-1)] on `lane_phase[4(k-1)+3 : 4(k-1)]` when its load step is applied.
- R4: With `bus_wide` = 1 all four byte lanes are sequenced. With `bus_wide` = 0 only lanes 1 and 2 are sequenced, and the phase, disable and nreset outputs of lanes 3 and 4 keep their previous values for the whole run.
- R5: The load step drives disable = 1 and nreset = 0 on the lane group and holds for exactly 2 µs worth of cycles (CLK_MHZ*2). The command-lane load step is applied on the clock edge that samples `start`.
- R6: The release step drives disable = 0 and nreset = 0 and holds for exactly CLK_MHZ*22 cycles.
- R7: The run step drives disable = 0 and nreset = 1 and holds for exactly CLK_MHZ*22 cycles before the next action.
- R8: All active byte lanes change their controls and phases on the same clock edge.
- R9: The command lane completes all three steps before any byte-lane output changes. The byte-lane load step follows the command-lane run-step wait directly.
- R10: `done` is high for exactly one cycle, starting CLK_MHZ*22 cycles after the byte-lane run step.
- R11: A `start` pulse while a sequence is in progress has no effect on any output.
- R12: No DLL ever has disable = 1 and nreset = 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (sampled while idle) |
| phase_word | input | 32 | Packed command-lane and byte-lane phase settings |
| bus_wide | input | 1 | 1 = 32-bit bus (4 byte lanes), 0 = 16-bit bus (2 byte lanes) |
| cmd_phase | output | 6 | Command-lane DLL phase |
| lane_phase | output | 16 | Byte-lane DLL phases, 4 bits per lane, lane 1 in the low nibble |
| dll_dis | output | 5 | DLL disable controls; bit 0 is the command lane, bits 1..4 the byte lanes |
| dll_nrst | output | 5 | DLL active-low reset controls, same bit order |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume `phase_word` and `bus_wide` are meaningful only in the cycle that `start` is sampled in the idle state. They also assume that any later `start` arrives either during a run, where it must be ignored, or after `done`. The stimulus holds to this. It drives `start` for a single cycle at a time and then scrambles the word and width inputs, so that any later sampling shows up as an output mismatch. It issues one extra `start` in the middle of a run and begins each new sequence only after the previous `done` pulse has been observed.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

    localparam int BYTE_LANES   = 4;
    localparam int NARROW_LANES = 2;
    localparam int NUM_DLL      = BYTE_LANES + 1;
    localparam int LANE_PH_W    = 4;
    localparam int CMD_PH_W     = 6;
    localparam int CMD_PH_LSB   = 16;
    localparam int WORD_W       = 32;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_RUN     = 2'd2
    } step_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e                      state;
        logic                            pass;
        step_e                           step;
        logic [WORD_W-1:0]               word;
        logic                            wide;
        logic [NUM_DLL-1:0]              dis;
        logic [NUM_DLL-1:0]              nrst;
        logic [CMD_PH_W-1:0]             cmd_ph;
        logic [BYTE_LANES*LANE_PH_W-1:0] lane_ph;
        logic                            done;
    } seq_regs_t;

endpackage

// File: rtl/dllseq_timer.sv
module dllseq_timer #(
    parameter int SHORT_CYC = 250,
    parameter int LONG_CYC  = 2750,
    localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load) begin
            cnt_d = sel_long ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_d = 1'b0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign expire = run_q && (cnt_q == '0);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LONG_CYC - 1));

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dllseq_unpack.sv
module dllseq_unpack
    import dllseq_pkg::*;
(
    input  logic [WORD_W-1:0]               word,
    input  logic                            wide,
    output logic [CMD_PH_W-1:0]             cmd_ph,
    output logic [BYTE_LANES*LANE_PH_W-1:0] lane_ph,
    output logic [BYTE_LANES-1:0]           lane_act
);

    assign cmd_ph = word[CMD_PH_LSB +: CMD_PH_W];

    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_lane
        assign lane_ph[g*LANE_PH_W +: LANE_PH_W] = word[g*LANE_PH_W +: LANE_PH_W];
        if (g < NARROW_LANES) begin : g_always
            assign lane_act[g] = 1'b1;
        end else begin : g_wide_only
            assign lane_act[g] = wide;
        end
    end

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
    import dllseq_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int SHORT_US = 2,
    parameter int LONG_US  = 22,
    localparam int SHORT_CYC = CLK_MHZ * SHORT_US,
    localparam int LONG_CYC  = CLK_MHZ * LONG_US
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [WORD_W-1:0]               phase_word,
    input  logic                            bus_wide,
    output logic [CMD_PH_W-1:0]             cmd_phase,
    output logic [BYTE_LANES*LANE_PH_W-1:0] lane_phase,
    output logic [NUM_DLL-1:0]              dll_dis,
    output logic [NUM_DLL-1:0]              dll_nrst,
    output logic                            done
);

    seq_regs_t d, q;

    logic                            t_load;
    logic                            t_long;
    logic                            t_expire;
    logic [WORD_W-1:0]               src_word;
    logic                            src_wide;
    logic [CMD_PH_W-1:0]             u_cmd_ph;
    logic [BYTE_LANES*LANE_PH_W-1:0] u_lane_ph;
    logic [BYTE_LANES-1:0]           u_act;

    // While idle, decode the live inputs so the first step uses them directly.
    assign src_word = (q.state == SQ_IDLE) ? phase_word : q.word;
    assign src_wide = (q.state == SQ_IDLE) ? bus_wide   : q.wide;

    dllseq_unpack u_unpack (
        .word     (src_word),
        .wide     (src_wide),
        .cmd_ph   (u_cmd_ph),
        .lane_ph  (u_lane_ph),
        .lane_act (u_act)
    );

    dllseq_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .sel_long (t_long),
        .expire   (t_expire)
    );

    always_comb begin
        logic             apply;
        logic             grp_bytes;
        step_e            stp;
        logic [NUM_DLL-1:0] mask;

        d         = q;
        d.done    = 1'b0;
        t_load    = 1'b0;
        t_long    = 1'b0;
        apply     = 1'b0;
        grp_bytes = q.pass;
        stp       = q.step;

        unique case (q.state)
            SQ_IDLE: begin
                if (start) begin
                    d.state   = SQ_BUSY;
                    d.pass    = 1'b0;
                    d.step    = ST_LOAD;
                    d.word    = phase_word;
                    d.wide    = bus_wide;
                    apply     = 1'b1;
                    grp_bytes = 1'b0;
                    stp       = ST_LOAD;
                end
            end
            SQ_BUSY: begin
                if (t_expire) begin
                    if (q.step != ST_RUN) begin
                        stp    = (q.step == ST_LOAD) ? ST_RELEASE : ST_RUN;
                        d.step = stp;
                        apply  = 1'b1;
                    end else if (!q.pass) begin
                        d.pass    = 1'b1;
                        d.step    = ST_LOAD;
                        stp       = ST_LOAD;
                        grp_bytes = 1'b1;
                        apply     = 1'b1;
                    end else begin
                        d.state = SQ_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase

        mask = grp_bytes ? {u_act, 1'b0} : NUM_DLL'(1);

        if (apply) begin
            t_load = 1'b1;
            t_long = (stp != ST_LOAD);
            for (int j = 0; j < NUM_DLL; j++) begin
                if (mask[j]) begin
                    d.dis[j]  = (stp == ST_LOAD);
                    d.nrst[j] = (stp == ST_RUN);
                end
            end
            if (stp == ST_LOAD) begin
                if (!grp_bytes) begin
                    d.cmd_ph = u_cmd_ph;
                end else begin
                    for (int k = 0; k < BYTE_LANES; k++) begin
                        if (u_act[k]) begin
                            d.lane_ph[k*LANE_PH_W +: LANE_PH_W] =
                                u_lane_ph[k*LANE_PH_W +: LANE_PH_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= SQ_IDLE;
            q.pass    <= 1'b0;
            q.step    <= ST_LOAD;
            q.word    <= '0;
            q.wide    <= 1'b0;
            q.dis     <= '1;
            q.nrst    <= '0;
            q.cmd_ph  <= '0;
            q.lane_ph <= '0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_phase  = q.cmd_ph;
    assign lane_phase = q.lane_ph;
    assign dll_dis    = q.dis;
    assign dll_nrst   = q.nrst;
    assign done       = q.done;

    // R12
    no_dis_with_nrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_dis & dll_nrst) == '0);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    cmd_phase_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_phase) |-> (dll_dis[0] && !dll_nrst[0]));

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_BUSY && start) |=> ($stable(q.word) && $stable(q.wide)));

    // R4
    narrow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_BUSY && !q.wide) |=>
            ($stable(dll_dis[NUM_DLL-1:NARROW_LANES+1]) &&
             $stable(dll_nrst[NUM_DLL-1:NARROW_LANES+1])));

    // R9
    bytes_wait_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_BUSY && !q.pass) |=>
            ($stable(dll_dis[NUM_DLL-1:1]) || q.pass));

endmodule

// File: tb/dll_bringup_seq_bench.sv
module dll_bringup_seq_bench;

    localparam int CLK_MHZ = 125;
    localparam int S = CLK_MHZ * 2;
    localparam int L = CLK_MHZ * 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] phase_word = '0;
    logic        bus_wide = 1'b0;
    logic [5:0]  cmd_phase;
    logic [15:0] lane_phase;
    logic [4:0]  dll_dis;
    logic [4:0]  dll_nrst;
    logic        done;

    always #4 clk = ~clk;

    dll_bringup_seq #(.CLK_MHZ(CLK_MHZ)) u_dll_bringup_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase_word (phase_word),
        .bus_wide   (bus_wide),
        .cmd_phase  (cmd_phase),
        .lane_phase (lane_phase),
        .dll_dis    (dll_dis),
        .dll_nrst   (dll_nrst),
        .done       (done)
    );

    typedef struct {
        int          t;
        logic [32:0] v;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    int total = 0;
    int bad = 0;
    int tick = 0;
    int start_tick = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    logic [4:0]  m_dis = 5'h1f;
    logic [4:0]  m_nrst = 5'h00;
    logic [5:0]  m_cmd = '0;
    logic [15:0] m_lane = '0;
    logic        m_done = 1'b0;

    function automatic logic [32:0] snap();
        return {done, dll_dis, dll_nrst, cmd_phase, lane_phase};
    endfunction

    task automatic push(input int t, input string tag);
        exp_t e;
        e.t = t;
        e.v = {m_done, m_dis, m_nrst, m_cmd, m_lane};
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) tick <= tick + 1;

    // Monitor: every output change must match the next queued expectation.
    logic [32:0] prev;
    always @(negedge clk) begin
        if (mon_en) begin
            logic [32:0] cur;
            cur = snap();
            if (cur !== prev) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R11 unexpected output change", 64'(cur), 64'(prev));
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(cur === e.v, e.tag, 64'(cur), 64'(e.v));
                    check((tick - start_tick) == e.t, {e.tag, " timing"},
                          64'(tick - start_tick), 64'(e.t));
                end
                prev = cur;
            end
        end
    end

    task automatic run_seq(input logic [31:0] w, input logic wide, input bit poke);
        logic [4:0] act;
        act = wide ? 5'b11110 : 5'b00110;
        // command lane pass
        m_cmd = w[21:16]; m_dis[0] = 1'b1; m_nrst[0] = 1'b0;
        push(1, "R2 R5 cmd load");
        m_dis[0] = 1'b0;
        push(1 + S, "R6 cmd release");
        m_nrst[0] = 1'b1;
        push(1 + S + L, "R7 cmd run");
        // byte lanes pass
        for (int k = 1; k <= 4; k++) begin
            if (act[k]) begin
                m_lane[(k-1)*4 +: 4] = w[(k-1)*4 +: 4];
                m_dis[k] = 1'b1;
                m_nrst[k] = 1'b0;
            end
        end
        push(1 + S + 2*L, "R3 R4 R8 R9 lane load");
        m_dis = m_dis & ~act;
        push(1 + 2*S + 2*L, "R6 R8 lane release");
        m_nrst = m_nrst | act;
        push(1 + 2*S + 3*L, "R7 R8 lane run");
        m_done = 1'b1;
        push(1 + 2*S + 4*L, "R10 done rise");
        m_done = 1'b0;
        push(2 + 2*S + 4*L, "R10 done fall");

        @(negedge clk);
        start_tick = tick;
        start = 1'b1;
        phase_word = w;
        bus_wide = wide;
        @(negedge clk);
        start = 1'b0;
        phase_word = ~w;
        bus_wide = ~wide;
        if (poke) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (L) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=done", tick);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dll_dis === 5'h1f, "R1 dis reset", 64'(dll_dis), 64'h1f);
        check(dll_nrst === 5'h00, "R1 nrst reset", 64'(dll_nrst), 64'h0);
        check(cmd_phase === 6'h0 && lane_phase === 16'h0, "R1 phase reset",
              64'({cmd_phase, lane_phase}), 64'h0);
        check(done === 1'b0, "R1 done reset", 64'(done), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        prev = snap();
        mon_en = 1'b1;

        // narrow bus from reset: lanes 3,4 keep reset values (R4)
        run_seq(32'hC935_7A12, 1'b0, 1'b0);
        check(lane_phase[15:8] === 8'h00 && dll_dis[4:3] === 2'b11 && dll_nrst[4:3] === 2'b00,
              "R4 narrow lanes untouched", 64'({lane_phase[15:8], dll_dis[4:3], dll_nrst[4:3]}),
              64'({8'h00, 2'b11, 2'b00}));
        // wide bus
        run_seq(32'h002A_8C53, 1'b1, 1'b0);
        // narrow again with extra start pulses mid-run (R11), lanes 3,4 hold 8,C
        run_seq(32'h0015_F0E1, 1'b0, 1'b1);
        check(lane_phase[15:8] === 8'h8C, "R4 narrow keeps prior phases",
              64'(lane_phase[15:8]), 64'h8C);
        // all ones, upper word bits ignored (R2)
        run_seq(32'hFFFF_FFFF, 1'b1, 1'b0);
        check(cmd_phase === 6'h3F, "R2 cmd phase all ones", 64'(cmd_phase), 64'h3F);

        check(sbq.size() == 0, "R10 scoreboard drained", 64'(sbq.size()), 64'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule